// File: doc/BRIEF.md
# BF16 Group Accumulator with Bias and ReLU

This block is the summing stage of a small convolution accelerator. It takes a stream of 16-bit brain-float words on a fixed 16-bit input bus. One word selects the operation and a short setup phase follows. After that, every word is a data value. The values are summed in groups of a programmed size, a stored bias is added to each group sum, and negative results are clamped to zero (ReLU). Each 16-bit result leaves on an 8-bit output bus over two back-to-back cycles.

A driver starts an operation by presenting the start code. It then presents a word that carries the group size and a word that carries the bias. Data words follow, one per cycle, with no gaps needed. A dedicated stop word sends the block back to idle. In idle it waits for the next start code. The `outValid` strobe is provided so that verification can see which output cycles carry data. A real driver works out those cycles from the fixed latency.

Top module: `bf16_accum`

## Requirements
- R1: Values are coded as 1 sign bit [15], 8 exponent bits [14:7] with bias 127, and 7 fraction bits [6:0]. When every operand and every partial sum can be represented exactly, each result is the exact value of ReLU(group sum + bias).
- R2: In idle, the word 16'hA000 starts an operation. The next word sets the group size: bits [3:0] hold the group size minus one. The word after that is the bias value. All later words are data.
- R3: Each group of consecutive data words produces one result. That result equals the sum of the group's values plus the bias, with ReLU applied.
- R4: Any result whose sign bit would be set comes out as 16'h0000.
- R5: Additions truncate toward zero. For example, 256.0 + 1.0 yields 16'h4380 (256.0).
- R6: An operand whose exponent field is zero counts as zero, whatever its fraction bits.
- R7: Each result appears on `outByte` as its low byte first and then its high byte, in two consecutive cycles. `outValid` is high in both of those cycles.
- R8: The low byte is on the output after the third rising clock edge that follows the edge which samples the last data word of its group.
- R9: In reset, and in every cycle that carries no result byte, `outValid` is 0 and `outByte` is 8'h00.
- R10: During the data phase, the word 16'hFFFE returns the block to idle. Any partial group is dropped. Results already in flight are still sent. Words that arrive afterwards have no effect until the next 16'hA000.
- R11: A group-size field of 0 is treated as a group of two values.
- R12: In idle, every word other than 16'hA000 is ignored and no output is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic samples on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inWord | input | 16 | Operation code, setup word or data value, one word per cycle |
| outByte | output | 8 | Result byte, low half first; 8'h00 when not valid |
| outValid | output | 1 | High in the cycles that carry a result byte (for verification) |

## Verification
Each result is scheduled at the moment the bench drives the last value of its group. The bench notes the rising edge that will sample that value, call it k. It then expects the low byte at the first falling edge after edge k+3 and the high byte one cycle later. A monitor samples at every falling edge. It compares each cycle against that schedule and requires a quiet bus in every cycle that has no scheduled byte. Because of this, a result that arrives early, late, in the wrong byte order, or that should never have appeared is caught in the exact cycle where it goes wrong.

// File: rtl/bf16_accum_pkg.sv
package bf16_accum_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 7;
  localparam int MANT_W = FRAC_W + 2;  // hidden bit + fraction + guard bit

  localparam logic [WORD_W-1:0] START_CODE = 16'hA000;
  localparam logic [WORD_W-1:0] STOP_CODE  = 16'hFFFE;

  typedef struct packed {
    logic biasEn;   // current word is the bias
    logic dataEn;   // current word is a data value
    logic first;    // data value opens a group
    logic last;     // data value closes a group
  } ctlStrobe_t;

  // Truncating add: exponent alignment, one guard bit, zero flush.
  function automatic logic [WORD_W-1:0] bfAdd(input logic [WORD_W-1:0] a,
                                              input logic [WORD_W-1:0] b);
    logic              aZero, bZero, swap;
    logic [WORD_W-1:0] big, sml, res;
    logic [EXP_W-1:0]  eBig, eDiff;
    logic [MANT_W-1:0] mBig, mSml, mDiff, mNorm;
    logic [MANT_W:0]   mSum;
    logic [3:0]        lz;
    aZero = (a[14:7] == '0);
    bZero = (b[14:7] == '0);
    res   = '0;
    lz    = '0;
    swap  = (b[14:0] > a[14:0]);
    big   = swap ? b : a;
    sml   = swap ? a : b;
    eBig  = big[14:7];
    eDiff = big[14:7] - sml[14:7];
    mBig  = {1'b1, big[6:0], 1'b0};
    mSml  = {1'b1, sml[6:0], 1'b0} >> eDiff;
    mSum  = {1'b0, mBig} + {1'b0, mSml};
    mDiff = mBig - mSml;
    for (int i = 0; i < MANT_W; i++) begin
      if (mDiff[i]) lz = 4'(MANT_W - 1 - i);
    end
    mNorm = mDiff << lz;
    if (aZero && bZero) res = {a[15] & b[15], 15'd0};
    else if (aZero) res = b;
    else if (bZero) res = a;
    else if (big[15] == sml[15]) begin
      if (mSum[MANT_W]) res = {big[15], eBig + 8'd1, mSum[MANT_W-1:2]};
      else              res = {big[15], eBig, mSum[MANT_W-2:1]};
    end else begin
      if (mDiff == '0)              res = '0;
      else if (eBig <= {4'd0, lz})  res = {big[15], 15'd0};
      else                          res = {big[15], eBig - {4'd0, lz}, mNorm[MANT_W-2:1]};
    end
    return res;
  endfunction

endpackage

// File: rtl/bf16_accum_ctrl.sv
module bf16_accum_ctrl
  import bf16_accum_pkg::*;
#(
  parameter int SIZE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  output ctlStrobe_t        ctl
);

  typedef enum logic [1:0] {S_IDLE, S_SIZE, S_BIAS, S_RUN} ctlState_t;

  ctlState_t         state;
  logic [SIZE_W-1:0] sizeM1;
  logic [SIZE_W-1:0] cnt;
  ctlStrobe_t        ctlNext;
  logic              isStop;

  assign isStop = (inWord == STOP_CODE);

  always_comb begin
    ctlNext = '0;
    case (state)
      S_BIAS: ctlNext.biasEn = 1'b1;
      S_RUN: begin
        if (!isStop) begin
          ctlNext.dataEn = 1'b1;
          ctlNext.first  = (cnt == '0);
          ctlNext.last   = (cnt == sizeM1);
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      sizeM1 <= SIZE_W'(1);
      cnt    <= '0;
      ctl    <= '0;
    end else begin
      ctl <= ctlNext;
      case (state)
        S_IDLE: if (inWord == START_CODE) state <= S_SIZE;
        S_SIZE: begin
          sizeM1 <= (inWord[SIZE_W-1:0] == '0) ? SIZE_W'(1) : inWord[SIZE_W-1:0];
          cnt    <= '0;
          state  <= S_BIAS;
        end
        S_BIAS: state <= S_RUN;
        S_RUN: begin
          if (isStop) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= ctlNext.last ? '0 : cnt + SIZE_W'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: the effective group is never a single value
  a_r11_size_min_two: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> (sizeM1 != '0));

  // R12: idle words never reach the datapath as data
  a_r12_idle_no_data: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |=> !ctl.dataEn);

  // R10: the stop word yields no data strobe and leaves the run state
  a_r10_stop_exits: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && isStop) |=> (state == S_IDLE && !ctl.dataEn));

endmodule

// File: rtl/bf16_accum_dp.sv
module bf16_accum_dp
  import bf16_accum_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inWord,
  input  ctlStrobe_t        ctl,
  output logic [BYTE_W-1:0] outByte,
  output logic              outValid
);

  logic [WORD_W-1:0] inReg, accReg, biasReg, sumReg, resReg, sumIn, biased;
  logic [BYTE_W-1:0] hiByte;
  logic              sumValid, resValid, hiPend;

  assign sumIn  = bfAdd(ctl.first ? '0 : accReg, inReg);
  assign biased = bfAdd(sumReg, biasReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg    <= '0;
      accReg   <= '0;
      biasReg  <= '0;
      sumReg   <= '0;
      sumValid <= 1'b0;
      resReg   <= '0;
      resValid <= 1'b0;
      outByte  <= '0;
      hiByte   <= '0;
      hiPend   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      inReg <= inWord;
      // stage 1: group accumulation
      if (ctl.biasEn) biasReg <= inReg;
      if (ctl.dataEn) accReg <= sumIn;
      if (ctl.dataEn && ctl.last) sumReg <= sumIn;
      sumValid <= ctl.dataEn && ctl.last;
      // stage 2: bias and ReLU
      resValid <= sumValid;
      if (sumValid) resReg <= biased[WORD_W-1] ? '0 : biased;
      // stage 3: byte serialiser, low half first
      if (resValid) begin
        outByte  <= resReg[BYTE_W-1:0];
        hiByte   <= resReg[WORD_W-1:BYTE_W];
        hiPend   <= 1'b1;
        outValid <= 1'b1;
      end else if (hiPend) begin
        outByte  <= hiByte;
        hiPend   <= 1'b0;
        outValid <= 1'b1;
      end else begin
        outByte  <= '0;
        outValid <= 1'b0;
      end
    end
  end

  // R4: ReLU output is never negative
  a_r4_relu_nonneg: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !resReg[WORD_W-1]);

  // R7: a low byte is always followed by its high byte
  a_r7_byte_pair: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |=> outValid);

  // R7: a new result never lands while a high byte is pending
  a_r7_no_clash: assert property (@(posedge clk) disable iff (!rstN)
    hiPend |-> !resValid);

  // R8: group close to first output byte is a fixed distance
  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.dataEn && ctl.last) |=> ##2 outValid);

  // R9: a quiet output cycle carries a zero byte
  a_r9_quiet_zero: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (outByte == '0));

endmodule

// File: rtl/bf16_accum.sv
module bf16_accum
  import bf16_accum_pkg::*;
#(
  parameter int SIZE_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] inWord,
  output logic [7:0]  outByte,
  output logic        outValid
);

  ctlStrobe_t ctl;

  bf16_accum_ctrl #(.SIZE_W(SIZE_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inWord (inWord),
    .ctl    (ctl)
  );

  bf16_accum_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inWord   (inWord),
    .ctl      (ctl),
    .outByte  (outByte),
    .outValid (outValid)
  );

endmodule

// File: tb/test_bf16_accum.sv
module test_bf16_accum;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] inWord = 16'h0000;
  logic [7:0]  outByte;
  logic        outValid;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    monOn = 0;
  bit    done = 0;
  string quietTag = "R9";
  logic [7:0] expB [int];
  string      expTag [int];

  bf16_accum i_bf16_accum (
    .clk(clk), .rstN(rstN), .inWord(inWord), .outByte(outByte), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] real2bf(input real r);
    real a;
    int  e, frac;
    logic s;
    if (r == 0.0) return 16'h0000;
    s = (r < 0.0);
    a = s ? -r : r;
    e = 127;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0)  begin a = a * 2.0; e--; end
    frac = int'($floor((a - 1.0) * 128.0));
    return {s, 8'(e), 7'(frac)};
  endfunction

  task automatic sendWord(input logic [15:0] w, output int k);
    @(negedge clk);
    inWord = w;
    k = cyc + 1;
  endtask

  task automatic expectRes(input int k, input logic [15:0] r, input string tag);
    expB[k+3] = r[7:0];   expTag[k+3] = tag;
    expB[k+4] = r[15:8];  expTag[k+4] = tag;
  endtask

  // monitor: compares every cycle to the schedule
  always @(negedge clk) begin
    if (monOn && !done) begin
      checks++;
      if (expB.exists(cyc)) begin
        if (!outValid || outByte != expB[cyc]) begin
          errors++;
          $display("FAIL %s (R7 R8) cycle %0d: valid=%0b byte=%02h expected valid=1 byte=%02h",
                   expTag[cyc], cyc, outValid, outByte, expB[cyc]);
        end
        expB.delete(cyc);
        expTag.delete(cyc);
      end else if (outValid || outByte != 8'h00) begin
        errors++;
        $display("FAIL %s cycle %0d: valid=%0b byte=%02h expected valid=0 byte=00",
                 quietTag, cyc, outValid, outByte);
      end
    end
  end

  task automatic randomOp();
    int k, f, sz, lim, nG, v;
    real bias, s, t;
    f   = int'($urandom_range(15, 0));
    sz  = (f == 0) ? 2 : f + 1;
    lim = (sz <= 8) ? 7 : 3;
    bias = (real'($urandom_range(30, 0)) - 15.0) * 0.5;
    sendWord(16'hA000, k);
    sendWord({12'h000, 4'(f)}, k);
    sendWord(real2bf(bias), k);
    nG = int'($urandom_range(3, 1));
    for (int g = 0; g < nG; g++) begin
      s = 0.0;
      for (int i = 0; i < sz; i++) begin
        v = int'($urandom_range(2*lim, 0)) - lim;
        s = s + real'(v);
        sendWord(real2bf(real'(v)), k);
      end
      t = s + bias;
      expectRes(k, (t > 0.0) ? real2bf(t) : 16'h0000, "R1");
    end
    if ($urandom_range(1, 0) == 1) sendWord(16'h3F80, k);  // R10 partial group dropped
    sendWord(16'hFFFE, k);
  endtask

  initial begin
    int k;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outByte !== 8'h00) begin
      errors++;
      $display("FAIL R9 reset: valid=%0b byte=%02h expected valid=0 byte=00", outValid, outByte);
    end
    rstN = 1'b1;
    monOn = 1;

    // R12: idle ignores anything but the start code
    quietTag = "R12";
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (w == 16'hA000) w = 16'h1234;
      sendWord(w, k);
    end
    quietTag = "R9";

    // R3/R4: two values per group, bias -3.5
    sendWord(16'hA000, k); sendWord(16'h0001, k); sendWord(16'hC060, k);
    sendWord(16'h3F80, k); sendWord(16'h4000, k); expectRes(k, 16'h0000, "R4");
    sendWord(16'h4040, k); sendWord(16'h4080, k); expectRes(k, 16'h4060, "R3");
    sendWord(16'hFFFE, k);

    // R2: group of four, bias 1.0 -> 1+2+3+4+1 = 11.0
    sendWord(16'hA000, k); sendWord(16'h0003, k); sendWord(16'h3F80, k);
    sendWord(16'h3F80, k); sendWord(16'h4000, k); sendWord(16'h4040, k);
    sendWord(16'h4080, k); expectRes(k, 16'h4130, "R2");
    sendWord(16'hFFFE, k);

    // R5: 256 + 1 truncates to 256
    sendWord(16'hA000, k); sendWord(16'h0001, k); sendWord(16'h0000, k);
    sendWord(16'h4380, k); sendWord(16'h3F80, k); expectRes(k, 16'h4380, "R5");
    sendWord(16'hFFFE, k);

    // R6: exponent-zero operand counts as zero
    sendWord(16'hA000, k); sendWord(16'h0001, k); sendWord(16'h0000, k);
    sendWord(16'h0055, k); sendWord(16'h4040, k); expectRes(k, 16'h4040, "R6");
    sendWord(16'hFFFE, k);

    // R11: size field 0 acts as two; R10: partial group dropped, later words ignored
    sendWord(16'hA000, k); sendWord(16'h0000, k); sendWord(16'h0000, k);
    sendWord(16'h3F80, k); sendWord(16'h3F80, k); expectRes(k, 16'h4000, "R11");
    sendWord(16'h4000, k);
    sendWord(16'hFFFE, k);
    quietTag = "R10";
    sendWord(16'h4000, k); sendWord(16'h4040, k); sendWord(16'h0003, k);
    repeat (6) @(negedge clk);
    quietTag = "R9";

    for (int n = 0; n < 25; n++) randomOp();

    repeat (8) @(negedge clk);
    checks++;
    if (expB.size() != 0) begin
      errors++;
      $display("FAIL R8 %0d scheduled bytes never seen, expected 0", expB.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20000 * CLK_PERIOD);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule